// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Flags

This block carries 18-bit words in one direction between two unrelated clock domains. Port A is the producer side, clocked by `a_clk`. Port B is the consumer side, clocked by `b_clk`. Each port has an active-low select, a direction bit and an active-low transfer enable. A transfer happens only when all three agree with the side's role: a write on port A, a read on port B. The block refuses writes when it is full and reads when it is empty.

Four active-low status outputs report the fill level. The empty and almost-empty indications are computed in the B domain, and the full and almost-full indications in the A domain. Each is derived from that domain's own pointer and from a Gray-coded copy of the far pointer that has passed through two flops. The two thresholds are run-time values. Each one sits in a register in the domain that uses it, and both reset to 8. A surrounding port decoder uses the block by steering its select, direction and enable lines, and loads the thresholds through the two configuration strobes.

Top module: `dcfifo_flagged`

## Requirements
- R1: After reset, `b_empty_n` and `b_aempty_n` are 0, `a_full_n` and `a_afull_n` are 1, `b_rdata` is 0, and both thresholds hold 8.
- R2: A word is written on a rising `a_clk` only when `a_sel_n`=0, `a_dir`=0 (write), `a_en_n`=0 and `a_full_n`=1. Any other combination stores nothing.
- R3: A read happens on a rising `b_clk` only when `b_sel_n`=0, `b_dir`=1 (read), `b_en_n`=0 and `b_empty_n`=1. `b_rdata` then registers the oldest word, and otherwise keeps its value.
- R4: Words leave port B in the order they entered port A, and none is lost or repeated, with the two clocks unrelated.
- R5: `b_empty_n` is 0 exactly when the B-side fill level is 0. A read attempted while it is 0 leaves `b_rdata` unchanged.
- R6: `a_full_n` is 0 exactly when the A-side fill level equals the depth. A write attempted while it is 0 changes nothing that is later read out.
- R7: `b_aempty_n` is 0 when the fill level is less than or equal to the almost-empty threshold, and 1 when the level is above it.
- R8: `a_afull_n` is 0 when the fill level is greater than depth minus the almost-full threshold, and 1 otherwise.
- R9: `a_cfg_we` loads `a_cfg_off` into the almost-full threshold on `a_clk`. `b_cfg_we` loads `b_cfg_off` into the almost-empty threshold on `b_clk`. Each threshold is ADDR_W+1 bits wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_clk | input | 1 | Producer clock |
| a_rst | input | 1 | Synchronous active-high reset, A domain |
| a_sel_n | input | 1 | Port A select, active low |
| a_dir | input | 1 | Port A direction, 0 = write |
| a_en_n | input | 1 | Port A transfer enable, active low |
| a_wdata | input | DATA_W | Word to store |
| a_cfg_we | input | 1 | Load the almost-full threshold |
| a_cfg_off | input | ADDR_W+1 | New almost-full threshold |
| a_full_n | output | 1 | Full, active low, A domain |
| a_afull_n | output | 1 | Almost full, active low, A domain |
| b_clk | input | 1 | Consumer clock |
| b_rst | input | 1 | Synchronous active-high reset, B domain |
| b_sel_n | input | 1 | Port B select, active low |
| b_dir | input | 1 | Port B direction, 1 = read |
| b_en_n | input | 1 | Port B transfer enable, active low |
| b_rdata | output | DATA_W | Last word read |
| b_cfg_we | input | 1 | Load the almost-empty threshold |
| b_cfg_off | input | ADDR_W+1 | New almost-empty threshold |
| b_empty_n | output | 1 | Empty, active low, B domain |
| b_aempty_n | output | 1 | Almost empty, active low, B domain |

## Verification
The bench tests each threshold on both sides of its boundary. With the default 8, levels 8 and 9 separate almost-empty, and levels 248 and 249 separate almost-full. With loaded thresholds of 3 and 5, levels 3 and 4, and 251 and 252, do the same. A comparison that is off by one, or inclusive on the wrong side, flips a flag at exactly one of those levels. The bench fills the store to its depth, attempts one more write, and then drains it. A design that overflowed would overwrite the oldest word or return an extra one. A design with a bad wrap of the extra pointer bit would report empty or full at the wrong time. Reads on an empty store, and transfers with any one qualifier wrong, must leave `b_rdata` and the fill level untouched. A design that ignored one of the qualifiers would show up there as a moved data register or a shifted fill level.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

    localparam int WORD_W       = 18;
    localparam int OFFSET_RESET = 8;

    typedef enum logic {
        DIR_WRITE = 1'b0,
        DIR_READ  = 1'b1
    } dir_e;

    typedef struct packed {
        logic sel_n;
        dir_e dir;
        logic en_n;
    } port_ctl_t;

    // Gray encode of an up-to-32-bit binary count
    function automatic logic [31:0] bin2gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    // Gray decode: each binary bit is the xor of all Gray bits at or above it
    function automatic logic [31:0] gray2bin(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    // A port moves data only when selected, enabled and pointed the right way
    function automatic logic xfer_req(input port_ctl_t c, input dir_e want);
        return !c.sel_n && (c.dir == want) && !c.en_n;
    endfunction

endpackage

// File: rtl/dcf_sync2.sv
module dcf_sync2 #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/dcf_mem.sv
module dcf_mem #(
    parameter int DATA_W = 18,
    parameter int ADDR_W = 8,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rclk,
    input  logic              rrst,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] store [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    always_ff @(posedge rclk) begin
        if (rrst) begin
            rdata <= '0;
        end else if (re) begin
            rdata <= store[raddr];
        end
    end
endmodule

// File: rtl/dcf_wr_ctrl.sv
module dcf_wr_ctrl
    import dcf_pkg::*;
#(
    parameter int ADDR_W = 8,
    localparam int PW    = ADDR_W + 1,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  port_ctl_t         ctl,
    input  logic              cfg_we,
    input  logic [PW-1:0]     cfg_off,
    input  logic [PW-1:0]     rgray_s,
    output logic              push,
    output logic [ADDR_W-1:0] waddr,
    output logic [PW-1:0]     wgray,
    output logic              full_n,
    output logic              afull_n
);
    logic [PW-1:0] wbin;
    logic [PW-1:0] rbin_s;
    logic [PW-1:0] level;
    logic [PW-1:0] af_off;
    logic [PW:0]   level_plus_off;

    assign rbin_s         = PW'(gray2bin(32'(rgray_s)));
    assign level          = wbin - rbin_s;
    assign full_n         = (level != PW'(DEPTH));
    assign level_plus_off = {1'b0, level} + {1'b0, af_off};
    assign afull_n        = !(level_plus_off > (PW+1)'(DEPTH));
    assign push           = xfer_req(ctl, DIR_WRITE) && full_n;
    assign waddr          = wbin[ADDR_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            wbin   <= '0;
            wgray  <= '0;
            af_off <= PW'(OFFSET_RESET);
        end else begin
            if (push) begin
                wbin  <= wbin + PW'(1);
                wgray <= PW'(bin2gray(32'(wbin + PW'(1))));
            end
            if (cfg_we) begin
                af_off <= cfg_off;
            end
        end
    end

    a_r1_reset_wr_flags: assert property (@(posedge clk)
        $past(rst) && !rst |-> full_n && afull_n)
        else $error("R1: write-side flags not idle after reset");

    a_r2_wptr_step: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (wbin == $past(wbin)) || (wbin == $past(wbin) + PW'(1)))
        else $error("R2: write pointer jumped");

    a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
        level <= PW'(DEPTH))
        else $error("R6: fill level beyond depth");

    a_r8_full_within_afull: assert property (@(posedge clk) disable iff (rst)
        (!full_n && af_off != '0) |-> !afull_n)
        else $error("R8: full without almost-full");

    a_r9_af_load: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> af_off == $past(cfg_off))
        else $error("R9: almost-full threshold not loaded");
endmodule

// File: rtl/dcf_rd_ctrl.sv
module dcf_rd_ctrl
    import dcf_pkg::*;
#(
    parameter int ADDR_W = 8,
    localparam int PW    = ADDR_W + 1,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  port_ctl_t         ctl,
    input  logic              cfg_we,
    input  logic [PW-1:0]     cfg_off,
    input  logic [PW-1:0]     wgray_s,
    output logic              pop,
    output logic [ADDR_W-1:0] raddr,
    output logic [PW-1:0]     rgray,
    output logic              empty_n,
    output logic              aempty_n
);
    logic [PW-1:0] rbin;
    logic [PW-1:0] wbin_s;
    logic [PW-1:0] level;
    logic [PW-1:0] ae_off;

    assign wbin_s   = PW'(gray2bin(32'(wgray_s)));
    assign level    = wbin_s - rbin;
    assign empty_n  = (level != '0);
    assign aempty_n = (level > ae_off);
    assign pop      = xfer_req(ctl, DIR_READ) && empty_n;
    assign raddr    = rbin[ADDR_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            rbin   <= '0;
            rgray  <= '0;
            ae_off <= PW'(OFFSET_RESET);
        end else begin
            if (pop) begin
                rbin  <= rbin + PW'(1);
                rgray <= PW'(bin2gray(32'(rbin + PW'(1))));
            end
            if (cfg_we) begin
                ae_off <= cfg_off;
            end
        end
    end

    a_r1_reset_rd_flags: assert property (@(posedge clk)
        $past(rst) && !rst |-> !empty_n && !aempty_n)
        else $error("R1: read-side flags not idle after reset");

    a_r3_rptr_step: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (rbin == $past(rbin)) || (rbin == $past(rbin) + PW'(1)))
        else $error("R3: read pointer jumped");

    a_r5_no_underflow: assert property (@(posedge clk) disable iff (rst)
        level <= PW'(DEPTH))
        else $error("R5: read pointer passed write pointer");

    a_r7_empty_within_aempty: assert property (@(posedge clk) disable iff (rst)
        !empty_n |-> !aempty_n)
        else $error("R7: empty without almost-empty");

    a_r9_ae_load: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> ae_off == $past(cfg_off))
        else $error("R9: almost-empty threshold not loaded");
endmodule

// File: rtl/dcfifo_flagged.sv
module dcfifo_flagged
    import dcf_pkg::*;
#(
    parameter int DATA_W = WORD_W,
    parameter int ADDR_W = 8,
    localparam int PW    = ADDR_W + 1
) (
    input  logic              a_clk,
    input  logic              a_rst,
    input  logic              a_sel_n,
    input  logic              a_dir,
    input  logic              a_en_n,
    input  logic [DATA_W-1:0] a_wdata,
    input  logic              a_cfg_we,
    input  logic [PW-1:0]     a_cfg_off,
    output logic              a_full_n,
    output logic              a_afull_n,
    input  logic              b_clk,
    input  logic              b_rst,
    input  logic              b_sel_n,
    input  logic              b_dir,
    input  logic              b_en_n,
    output logic [DATA_W-1:0] b_rdata,
    input  logic              b_cfg_we,
    input  logic [PW-1:0]     b_cfg_off,
    output logic              b_empty_n,
    output logic              b_aempty_n
);
    port_ctl_t         a_ctl, b_ctl;
    logic              push, pop;
    logic [ADDR_W-1:0] waddr, raddr;
    logic [PW-1:0]     wgray, rgray, wgray_in_b, rgray_in_a;

    assign a_ctl = '{sel_n: a_sel_n, dir: dir_e'(a_dir), en_n: a_en_n};
    assign b_ctl = '{sel_n: b_sel_n, dir: dir_e'(b_dir), en_n: b_en_n};

    dcf_wr_ctrl #(.ADDR_W(ADDR_W)) u_wr (
        .clk(a_clk), .rst(a_rst), .ctl(a_ctl),
        .cfg_we(a_cfg_we), .cfg_off(a_cfg_off),
        .rgray_s(rgray_in_a), .push(push), .waddr(waddr), .wgray(wgray),
        .full_n(a_full_n), .afull_n(a_afull_n)
    );

    dcf_rd_ctrl #(.ADDR_W(ADDR_W)) u_rd (
        .clk(b_clk), .rst(b_rst), .ctl(b_ctl),
        .cfg_we(b_cfg_we), .cfg_off(b_cfg_off),
        .wgray_s(wgray_in_b), .pop(pop), .raddr(raddr), .rgray(rgray),
        .empty_n(b_empty_n), .aempty_n(b_aempty_n)
    );

    dcf_sync2 #(.W(PW)) u_w2b (
        .clk(b_clk), .rst(b_rst), .d(wgray), .q(wgray_in_b)
    );

    dcf_sync2 #(.W(PW)) u_r2a (
        .clk(a_clk), .rst(a_rst), .d(rgray), .q(rgray_in_a)
    );

    dcf_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
        .wclk(a_clk), .we(push), .waddr(waddr), .wdata(a_wdata),
        .rclk(b_clk), .rrst(b_rst), .re(pop), .raddr(raddr), .rdata(b_rdata)
    );
endmodule

// File: tb/dcfifo_flagged_test.sv
module dcfifo_flagged_test;
    localparam int DW    = 18;
    localparam int AW    = 8;
    localparam int PW    = AW + 1;
    localparam int DEPTH = 1 << AW;
    localparam int NVEC  = 8;
    // each row: words to write, then words to read
    localparam int VEC [NVEC][2] = '{
        '{5, 0}, '{4, 2}, '{0, 7}, '{12, 3}, '{0, 9}, '{8, 0}, '{1, 0}, '{0, 9}
    };

    logic a_clk = 0, b_clk = 0;
    logic a_rst = 1, b_rst = 1;
    logic a_sel_n = 1, a_dir = 0, a_en_n = 1, a_cfg_we = 0;
    logic b_sel_n = 1, b_dir = 1, b_en_n = 1, b_cfg_we = 0;
    logic [DW-1:0] a_wdata = '0;
    logic [PW-1:0] a_cfg_off = '0, b_cfg_off = '0;
    logic [DW-1:0] b_rdata;
    logic a_full_n, a_afull_n, b_empty_n, b_aempty_n;

    int n_chk = 0, n_bad = 0, seq = 0;
    int ae_m = 8, af_m = 8;
    logic [DW-1:0] q[$];
    logic [DW-1:0] last_rd = '0;

    always #2 a_clk = ~a_clk;     // 250 MHz
    always #3.7 b_clk = ~b_clk;   // unrelated consumer clock

    dcfifo_flagged #(.DATA_W(DW), .ADDR_W(AW)) uut (
        .a_clk(a_clk), .a_rst(a_rst), .a_sel_n(a_sel_n), .a_dir(a_dir),
        .a_en_n(a_en_n), .a_wdata(a_wdata), .a_cfg_we(a_cfg_we),
        .a_cfg_off(a_cfg_off), .a_full_n(a_full_n), .a_afull_n(a_afull_n),
        .b_clk(b_clk), .b_rst(b_rst), .b_sel_n(b_sel_n), .b_dir(b_dir),
        .b_en_n(b_en_n), .b_rdata(b_rdata), .b_cfg_we(b_cfg_we),
        .b_cfg_off(b_cfg_off), .b_empty_n(b_empty_n), .b_aempty_n(b_aempty_n)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] mk_word(input int n);
        return DW'((n * 977 + 33) ^ (n << 5));
    endfunction

    task automatic do_write(input logic sel_n, input logic dir, input logic en_n);
        logic [DW-1:0] w;
        w = mk_word(seq);
        seq++;
        @(negedge a_clk);
        a_sel_n = sel_n; a_dir = dir; a_en_n = en_n; a_wdata = w;
        @(negedge a_clk);
        a_sel_n = 1; a_dir = 0; a_en_n = 1;
        if (!sel_n && !dir && !en_n && q.size() < DEPTH) q.push_back(w);
    endtask

    task automatic do_read(input logic sel_n, input logic dir, input logic en_n,
                           input string req);
        logic [DW-1:0] e;
        @(negedge b_clk);
        b_sel_n = sel_n; b_dir = dir; b_en_n = en_n;
        @(negedge b_clk);
        b_sel_n = 1; b_dir = 1; b_en_n = 1;
        if (!sel_n && dir && !en_n && q.size() > 0) begin
            e = q.pop_front();
            chk(b_rdata == e, "R4", "read word", int'(b_rdata), int'(e));
            last_rd = e;
        end else begin
            chk(b_rdata == last_rd, req, "rdata held", int'(b_rdata), int'(last_rd));
        end
    endtask

    task automatic settle();
        repeat (8) @(negedge a_clk);
        repeat (8) @(negedge b_clk);
    endtask

    task automatic check_flags(input string where);
        int c;
        c = q.size();
        chk(b_empty_n == (c != 0), "R5", {where, " empty_n"}, int'(b_empty_n), int'(c != 0));
        chk(b_aempty_n == (c > ae_m), "R7", {where, " aempty_n"}, int'(b_aempty_n), int'(c > ae_m));
        chk(a_full_n == (c != DEPTH), "R6", {where, " full_n"}, int'(a_full_n), int'(c != DEPTH));
        chk(a_afull_n == !(c > DEPTH - af_m), "R8", {where, " afull_n"},
            int'(a_afull_n), int'(!(c > DEPTH - af_m)));
    endtask

    task automatic set_offsets(input int ae, input int af);
        @(negedge b_clk); b_cfg_we = 1; b_cfg_off = PW'(ae);
        @(negedge b_clk); b_cfg_we = 0;
        @(negedge a_clk); a_cfg_we = 1; a_cfg_off = PW'(af);
        @(negedge a_clk); a_cfg_we = 0;
        ae_m = ae; af_m = af;
    endtask

    task automatic fill_to(input int target);
        while (q.size() < target) do_write(0, 0, 0);
        settle();
    endtask

    task automatic drain();
        while (q.size() > 0) do_read(0, 1, 0, "R4");
        settle();
    endtask

    initial begin
        repeat (150000) @(posedge a_clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge a_clk);
        a_rst = 0;
        @(negedge b_clk);
        b_rst = 0;
        repeat (2) @(negedge b_clk);

        // R1: reset state
        chk(b_empty_n == 0, "R1", "empty_n", int'(b_empty_n), 0);
        chk(b_aempty_n == 0, "R1", "aempty_n", int'(b_aempty_n), 0);
        chk(a_full_n == 1, "R1", "full_n", int'(a_full_n), 1);
        chk(a_afull_n == 1, "R1", "afull_n", int'(a_afull_n), 1);
        chk(b_rdata == 0, "R1", "rdata", int'(b_rdata), 0);

        // R2: writes with one qualifier wrong store nothing
        do_write(1, 0, 0);
        do_write(0, 1, 0);
        do_write(0, 0, 1);
        settle();
        chk(b_empty_n == 0, "R2", "ignored writes empty_n", int'(b_empty_n), 0);

        // R3: reads with one qualifier wrong leave rdata and level alone
        fill_to(2);
        do_read(1, 1, 0, "R3");
        do_read(0, 0, 0, "R3");
        do_read(0, 1, 1, "R3");
        settle();
        check_flags("R3 after ignored reads");
        drain();

        // Table: bursts with default thresholds (R1 defaults, R4 order)
        for (int v = 0; v < NVEC; v++) begin
            for (int k = 0; k < VEC[v][0]; k++) do_write(0, 0, 0);
            settle();
            check_flags("table after writes");
            for (int k = 0; k < VEC[v][1]; k++) do_read(0, 1, 0, "R4");
            settle();
            check_flags("table after reads");
        end

        // R8 at default threshold: 248 not almost full, 249 almost full
        fill_to(DEPTH - 8);
        check_flags("R8 default 248");
        fill_to(DEPTH - 7);
        check_flags("R8 default 249");
        // R6: full and one blocked write
        fill_to(DEPTH);
        check_flags("R6 full");
        do_write(0, 0, 0);
        settle();
        check_flags("R6 write while full");
        drain();
        check_flags("R6 drained");

        // R9: loaded thresholds, R7/R8 boundaries
        set_offsets(3, 5);
        fill_to(3);
        check_flags("R9 R7 level 3");
        fill_to(4);
        check_flags("R9 R7 level 4");
        fill_to(DEPTH - 5);
        check_flags("R9 R8 level 251");
        fill_to(DEPTH - 4);
        check_flags("R9 R8 level 252");
        drain();

        // R5: reads on empty leave rdata unchanged
        do_read(0, 1, 0, "R5");
        do_read(0, 1, 0, "R5");
        check_flags("R5 empty");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule